// File: doc/BRIEF.md
# Delayed Branch Fetch Sequencer

This block produces the next fetch address for a pipeline whose branches take effect only after a fixed number of delay-slot instructions. It takes one decoded instruction per accepted cycle, in program order. For each one it receives the branch kind, a likely flag, two operand values and a branch target. It evaluates the branch condition and counts the slot instructions that follow a branch. Once the last slot instruction has been accepted, it switches fetch to the target. No empty fetch cycles are inserted.

For every accepted instruction the block also emits a registered record. The record holds the instruction's address and whether it sits in a delay slot. It also holds the slot position, so that an exception handler can get back to the branch by stepping 4 bytes per position. A kill flag marks instructions that must continue down the pipe without writing state. An illegal flag marks a branch that was placed in another branch's delay slot. The instruction cache and the decoder sit outside the block. The surrounding logic presents the instruction found at `fetch_pc` and raises `in_valid` when its decode is ready.

Top module: `dbr_fetch_seq`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `fetch_pc` equals parameter RESET_PC (default 0x100) and `out_valid` is 0.
- R2: Each accepted instruction (`in_valid`=1) that does not end a taken branch's slot window advances `fetch_pc` by 4. A cycle with `in_valid`=0 leaves `fetch_pc` unchanged and produces `out_valid`=0 in the next cycle.
- R3: The branch kind `in_br_kind` is encoded as follows:
  - 0 is no branch.
  - 1 is taken when opa == opb.
  - 2 is taken when opa != opb.
  - 3 is taken when opa < 0.
  - 4 is taken when opa >= 0.
  - 5 is taken when opa <= 0.
  - 6 is taken when opa > 0.
  - 7 behaves as no branch.
  - Comparisons against zero treat opa as a signed two's-complement value.
- R4: The SLOTS instructions that follow a branch (parameter, default 2, minimum 1) are fetched at consecutive addresses. If the branch was taken, `fetch_pc` becomes the target directly after the last slot instruction is accepted, with no idle cycle.
- R5: For a branch that is not taken, fetch continues sequentially after the slots.
- R6: For an ordinary branch (`in_br_likely`=0), its slot instructions are reported with `out_annul`=0, whether or not the branch is taken.
- R7: For a likely branch (`in_br_likely`=1), its slot instructions are reported with `out_annul`=1 exactly when the branch is not taken. When the branch is taken they are reported with `out_annul`=0.
- R8: A slot instruction is reported with `out_in_slot`=1 and with `out_slot_idx` equal to its position after the branch (1 to SLOTS). Any other instruction is reported with `out_in_slot`=0 and `out_slot_idx`=0.
- R9: A branch accepted inside a delay slot is reported with `out_illegal`=1. It has no effect on the fetch sequence or on the current slot window.
- R10: The record for an accepted instruction appears on the outputs one cycle later, with `out_valid`=1 and `out_pc` equal to the `fetch_pc` at which it was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Decoded instruction at `fetch_pc` is presented this cycle |
| in_br_kind | input | 3 | Branch condition kind (R3 encoding) |
| in_br_likely | input | 1 | Branch is the likely variant |
| in_opa | input | DATA_W | First operand value |
| in_opb | input | DATA_W | Second operand value |
| in_target | input | ADDR_W | Branch target address |
| fetch_pc | output | ADDR_W | Address of the instruction to fetch |
| out_valid | output | 1 | Record below belongs to an accepted instruction |
| out_pc | output | ADDR_W | Address of that instruction |
| out_in_slot | output | 1 | Instruction occupies a delay slot |
| out_slot_idx | output | $clog2(SLOTS+1) | Position within the slot window, 0 if none |
| out_annul | output | 1 | Instruction is killed and must not write state |
| out_illegal | output | 1 | Branch found inside a delay slot |

## Verification
The assertions assume that a branch target presented outside a slot window is word aligned. They also assume that `in_valid` is the only qualifier: operand and target values are ignored in cycles where it is low. The bench keeps to this by using only targets that are multiples of 4 and by driving every input at the falling edge. It also follows the address the block asks for: each instruction it presents is the one at the currently expected `fetch_pc`. The scenarios cover the following cases:
- taken and not-taken outcomes of every condition kind, including signed operands at the zero boundary;
- both likely outcomes;
- the reserved kind;
- a branch placed inside a slot window;
- idle cycles between instructions.

// File: rtl/dbr_pkg.sv
package dbr_pkg;

  typedef enum logic [2:0] {
    BK_NONE = 3'd0,
    BK_EQ   = 3'd1,
    BK_NE   = 3'd2,
    BK_LTZ  = 3'd3,
    BK_GEZ  = 3'd4,
    BK_LEZ  = 3'd5,
    BK_GTZ  = 3'd6,
    BK_RSVD = 3'd7
  } br_kind_e;

  localparam int unsigned INSTR_BYTES = 4;

endpackage

// File: rtl/dbr_cond_eval.sv
module dbr_cond_eval
  import dbr_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [2:0]        kind,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  output logic              is_branch,
  output logic              taken
);

  logic a_zero;
  logic a_neg;

  assign a_zero = (opa == '0);
  assign a_neg  = opa[DATA_W-1];

  always_comb begin
    is_branch = 1'b1;
    taken     = 1'b0;
    unique case (br_kind_e'(kind))
      BK_EQ:   taken = (opa == opb);
      BK_NE:   taken = (opa != opb);
      BK_LTZ:  taken = a_neg;
      BK_GEZ:  taken = !a_neg;
      BK_LEZ:  taken = a_neg || a_zero;
      BK_GTZ:  taken = !a_neg && !a_zero;
      default: is_branch = 1'b0;
    endcase
  end

  // R3: a branch can only be taken if it is a real branch kind
  always_comb begin
    p_taken_needs_branch_r3: assert (!taken || is_branch);
  end

endmodule

// File: rtl/dbr_slot_ctrl.sv
module dbr_slot_ctrl #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned SLOTS  = 2,
  localparam int unsigned IDX_W = $clog2(SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              is_branch,
  input  logic              taken,
  input  logic              likely,
  input  logic [ADDR_W-1:0] target,
  output logic              in_slot,
  output logic [IDX_W-1:0]  slot_idx,
  output logic              annul_cur,
  output logic              redirect,
  output logic [ADDR_W-1:0] redirect_pc
);

  localparam logic [IDX_W-1:0] SLOTS_V = IDX_W'(SLOTS);
  localparam logic [IDX_W-1:0] ONE_V   = IDX_W'(1);

  logic [IDX_W-1:0]  left_q;
  logic              taken_q;
  logic              annul_q;
  logic [ADDR_W-1:0] target_q;

  assign in_slot     = (left_q != '0);
  assign slot_idx    = in_slot ? (SLOTS_V - left_q + ONE_V) : '0;
  assign annul_cur   = in_slot && annul_q;
  assign redirect    = accept && (left_q == ONE_V) && taken_q;
  assign redirect_pc = target_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q   <= '0;
      taken_q  <= 1'b0;
      annul_q  <= 1'b0;
      target_q <= '0;
    end else if (accept) begin
      if (in_slot) begin
        left_q <= left_q - ONE_V;
      end else if (is_branch) begin
        left_q   <= SLOTS_V;
        taken_q  <= taken;
        annul_q  <= likely && !taken;
        target_q <= target;
      end
    end
  end

  // R4: the remaining-slot count never exceeds the window size
  p_left_bound_r4: assert property (@(posedge clk) disable iff (rst)
    left_q <= SLOTS_V);

  // R9: a branch accepted inside a window does not restart the window
  p_no_restart_r9: assert property (@(posedge clk) disable iff (rst)
    (accept && in_slot) |=> (left_q == $past(left_q) - ONE_V));

endmodule

// File: rtl/dbr_pc_gen.sv
module dbr_pc_gen
  import dbr_pkg::*;
#(
  parameter int unsigned     ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] RESET_PC = 32'h100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              redirect,
  input  logic [ADDR_W-1:0] redirect_pc,
  output logic [ADDR_W-1:0] pc
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSTR_BYTES);

  logic [ADDR_W-1:0] pc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q <= RESET_PC;
    end else if (accept) begin
      pc_q <= redirect ? redirect_pc : pc_q + STEP;
    end
  end

  assign pc = pc_q;

  // R2: without an accepted instruction the fetch address holds
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !accept |=> $stable(pc_q));

endmodule

// File: rtl/dbr_fetch_seq.sv
module dbr_fetch_seq
  import dbr_pkg::*;
#(
  parameter int unsigned       DATA_W   = 32,
  parameter int unsigned       ADDR_W   = 32,
  parameter int unsigned       SLOTS    = 2,
  parameter logic [ADDR_W-1:0] RESET_PC = 32'h100,
  localparam int unsigned      IDX_W    = $clog2(SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [2:0]        in_br_kind,
  input  logic              in_br_likely,
  input  logic [DATA_W-1:0] in_opa,
  input  logic [DATA_W-1:0] in_opb,
  input  logic [ADDR_W-1:0] in_target,
  output logic [ADDR_W-1:0] fetch_pc,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_pc,
  output logic              out_in_slot,
  output logic [IDX_W-1:0]  out_slot_idx,
  output logic              out_annul,
  output logic              out_illegal
);

  logic              is_branch;
  logic              taken;
  logic              in_slot;
  logic [IDX_W-1:0]  slot_idx;
  logic              annul_cur;
  logic              redirect;
  logic [ADDR_W-1:0] redirect_pc;

  dbr_cond_eval #(.DATA_W(DATA_W)) u_cond (
    .kind      (in_br_kind),
    .opa       (in_opa),
    .opb       (in_opb),
    .is_branch (is_branch),
    .taken     (taken)
  );

  dbr_slot_ctrl #(.ADDR_W(ADDR_W), .SLOTS(SLOTS)) u_slot (
    .clk         (clk),
    .rst         (rst),
    .accept      (in_valid),
    .is_branch   (is_branch),
    .taken       (taken),
    .likely      (in_br_likely),
    .target      (in_target),
    .in_slot     (in_slot),
    .slot_idx    (slot_idx),
    .annul_cur   (annul_cur),
    .redirect    (redirect),
    .redirect_pc (redirect_pc)
  );

  dbr_pc_gen #(.ADDR_W(ADDR_W), .RESET_PC(RESET_PC)) u_pc (
    .clk         (clk),
    .rst         (rst),
    .accept      (in_valid),
    .redirect    (redirect),
    .redirect_pc (redirect_pc),
    .pc          (fetch_pc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      out_pc       <= '0;
      out_in_slot  <= 1'b0;
      out_slot_idx <= '0;
      out_annul    <= 1'b0;
      out_illegal  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_pc       <= fetch_pc;
        out_in_slot  <= in_slot;
        out_slot_idx <= slot_idx;
        out_annul    <= annul_cur;
        out_illegal  <= in_slot && is_branch;
      end
    end
  end

  // R4: a branch outside a window is followed by a sequential fetch
  p_seq_after_branch_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_slot && is_branch) |=> (fetch_pc == $past(fetch_pc) + ADDR_W'(INSTR_BYTES)));

  // R4: targets used for redirection are word aligned (input assumption)
  p_target_aligned_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_slot && is_branch) |-> (in_target[1:0] == 2'b00));

  // R7: only slot instructions can be killed
  p_annul_in_slot_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_annul) |-> out_in_slot);

  // R9: an illegal branch can only be reported from inside a window
  p_illegal_in_slot_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_illegal) |-> out_in_slot);

  // R8: the slot position is zero exactly for non-slot instructions
  p_idx_tag_r8: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_in_slot == (out_slot_idx != '0)));

  // R10: an idle input cycle yields no record
  p_idle_record_r10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

endmodule

// File: tb/tb_dbr_fetch_seq.sv
`timescale 1ns/1ps
module tb_dbr_fetch_seq;

  localparam int unsigned AW = 32;
  localparam logic [31:0] RST_PC = 32'h100;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [2:0]  in_br_kind = 3'd0;
  logic        in_br_likely = 1'b0;
  logic [31:0] in_opa = '0;
  logic [31:0] in_opb = '0;
  logic [31:0] in_target = '0;
  logic [31:0] fetch_pc;
  logic        out_valid;
  logic [31:0] out_pc;
  logic        out_in_slot;
  logic [1:0]  out_slot_idx;
  logic        out_annul;
  logic        out_illegal;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [31:0] epc;

  always #2.5 clk = ~clk;

  dbr_fetch_seq dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_br_kind(in_br_kind),
    .in_br_likely(in_br_likely), .in_opa(in_opa), .in_opb(in_opb),
    .in_target(in_target), .fetch_pc(fetch_pc), .out_valid(out_valid),
    .out_pc(out_pc), .out_in_slot(out_in_slot), .out_slot_idx(out_slot_idx),
    .out_annul(out_annul), .out_illegal(out_illegal)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Presents one instruction at the expected fetch address and checks its record.
  task automatic step(input string req, input logic [2:0] kind, input logic likely,
                      input logic [31:0] a, input logic [31:0] b, input logic [31:0] tgt,
                      input logic slot, input logic [1:0] idx, input logic ann,
                      input logic ill, input logic [31:0] nxt);
    chk(req, "fetch_pc before", fetch_pc, epc);
    in_valid = 1'b1; in_br_kind = kind; in_br_likely = likely;
    in_opa = a; in_opb = b; in_target = tgt;
    @(negedge clk);
    chk("R10", "out_valid", {31'd0, out_valid}, 32'd1);
    chk("R10", "out_pc", out_pc, epc);
    chk("R8", "out_in_slot", {31'd0, out_in_slot}, {31'd0, slot});
    chk("R8", "out_slot_idx", {30'd0, out_slot_idx}, {30'd0, idx});
    chk(req, "out_annul", {31'd0, out_annul}, {31'd0, ann});
    chk("R9", "out_illegal", {31'd0, out_illegal}, {31'd0, ill});
    chk(req, "fetch_pc after", fetch_pc, nxt);
    epc = nxt;
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0; in_br_kind = 3'd0; in_br_likely = 1'b0;
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk("R1", "fetch_pc in reset", fetch_pc, RST_PC);
    chk("R1", "out_valid in reset", {31'd0, out_valid}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "fetch_pc after reset", fetch_pc, RST_PC);
    chk("R1", "out_valid after reset", {31'd0, out_valid}, 32'd0);
    epc = RST_PC;
  endtask

  task automatic t_sequential;
    for (int i = 0; i < 3; i++)
      step("R2", 3'd0, 1'b0, 32'd5, 32'd5, 32'h0, 1'b0, 2'd0, 1'b0, 1'b0, epc + 4);
    idle(1);
  endtask

  task automatic t_taken_eq;
    logic [31:0] p = epc;
    step("R3", 3'd1, 1'b0, 32'd7, 32'd7, 32'h400, 1'b0, 2'd0, 1'b0, 1'b0, p + 4);
    step("R6", 3'd0, 1'b0, 0, 0, 0, 1'b1, 2'd1, 1'b0, 1'b0, p + 8);
    step("R4", 3'd0, 1'b0, 0, 0, 0, 1'b1, 2'd2, 1'b0, 1'b0, 32'h400);
    step("R4", 3'd0, 1'b0, 0, 0, 0, 1'b0, 2'd0, 1'b0, 1'b0, 32'h404);
    idle(1);
  endtask

  task automatic t_not_taken_ne;
    logic [31:0] p = epc;
    step("R3", 3'd2, 1'b0, 32'd9, 32'd9, 32'h800, 1'b0, 2'd0, 1'b0, 1'b0, p + 4);
    step("R6", 3'd0, 1'b0, 0, 0, 0, 1'b1, 2'd1, 1'b0, 1'b0, p + 8);
    step("R5", 3'd0, 1'b0, 0, 0, 0, 1'b1, 2'd2, 1'b0, 1'b0, p + 12);
    step("R5", 3'd0, 1'b0, 0, 0, 0, 1'b0, 2'd0, 1'b0, 1'b0, p + 16);
  endtask

  // Branch followed by two plain slots; reports whether fetch went to tgt.
  task automatic zero_cmp(input logic [2:0] kind, input logic [31:0] a,
                          input bit exp_taken, input logic [31:0] tgt);
    logic [31:0] p = epc;
    step("R3", kind, 1'b0, a, 32'hFFFF, tgt, 1'b0, 2'd0, 1'b0, 1'b0, p + 4);
    step("R3", 3'd0, 1'b0, 0, 0, 0, 1'b1, 2'd1, 1'b0, 1'b0, p + 8);
    step("R3", 3'd0, 1'b0, 0, 0, 0, 1'b1, 2'd2, 1'b0, 1'b0, exp_taken ? tgt : p + 12);
  endtask

  task automatic t_signed_zero;
    zero_cmp(3'd3, 32'hFFFF_FFFF, 1'b1, 32'h1000);
    zero_cmp(3'd3, 32'h0,         1'b0, 32'h1100);
    zero_cmp(3'd4, 32'h8000_0000, 1'b0, 32'h1200);
    zero_cmp(3'd4, 32'h0,         1'b1, 32'h1300);
    zero_cmp(3'd5, 32'h0,         1'b1, 32'h1400);
    zero_cmp(3'd5, 32'h1,         1'b0, 32'h1500);
    zero_cmp(3'd6, 32'h0,         1'b0, 32'h1600);
    zero_cmp(3'd6, 32'h7FFF_FFFF, 1'b1, 32'h1700);
    idle(2);
  endtask

  task automatic t_reserved_kind;
    logic [31:0] p = epc;
    step("R3", 3'd7, 1'b0, 32'd1, 32'd1, 32'h2000, 1'b0, 2'd0, 1'b0, 1'b0, p + 4);
    step("R3", 3'd0, 1'b0, 0, 0, 0, 1'b0, 2'd0, 1'b0, 1'b0, p + 8);
  endtask

  task automatic t_likely_not_taken;
    logic [31:0] p = epc;
    step("R7", 3'd1, 1'b1, 32'd1, 32'd2, 32'h3000, 1'b0, 2'd0, 1'b0, 1'b0, p + 4);
    step("R7", 3'd0, 1'b0, 0, 0, 0, 1'b1, 2'd1, 1'b1, 1'b0, p + 8);
    step("R7", 3'd0, 1'b0, 0, 0, 0, 1'b1, 2'd2, 1'b1, 1'b0, p + 12);
    step("R7", 3'd0, 1'b0, 0, 0, 0, 1'b0, 2'd0, 1'b0, 1'b0, p + 16);
  endtask

  task automatic t_likely_taken;
    logic [31:0] p = epc;
    step("R7", 3'd2, 1'b1, 32'd1, 32'd2, 32'h3400, 1'b0, 2'd0, 1'b0, 1'b0, p + 4);
    step("R7", 3'd0, 1'b0, 0, 0, 0, 1'b1, 2'd1, 1'b0, 1'b0, p + 8);
    step("R7", 3'd0, 1'b0, 0, 0, 0, 1'b1, 2'd2, 1'b0, 1'b0, 32'h3400);
    step("R7", 3'd0, 1'b0, 0, 0, 0, 1'b0, 2'd0, 1'b0, 1'b0, 32'h3404);
  endtask

  task automatic t_branch_in_slot;
    logic [31:0] p = epc;
    step("R9", 3'd2, 1'b0, 32'd3, 32'd4, 32'h5000, 1'b0, 2'd0, 1'b0, 1'b0, p + 4);
    step("R9", 3'd1, 1'b0, 32'd6, 32'd6, 32'h6000, 1'b1, 2'd1, 1'b0, 1'b1, p + 8);
    step("R9", 3'd0, 1'b0, 0, 0, 0, 1'b1, 2'd2, 1'b0, 1'b0, 32'h5000);
    step("R9", 3'd0, 1'b0, 0, 0, 0, 1'b0, 2'd0, 1'b0, 1'b0, 32'h5004);
  endtask

  task automatic t_stall;
    logic [31:0] p = epc;
    step("R2", 3'd1, 1'b0, 32'd2, 32'd2, 32'h7000, 1'b0, 2'd0, 1'b0, 1'b0, p + 4);
    idle(3);
    chk("R2", "fetch_pc held", fetch_pc, p + 4);
    chk("R2", "out_valid idle", {31'd0, out_valid}, 32'd0);
    step("R4", 3'd0, 1'b0, 0, 0, 0, 1'b1, 2'd1, 1'b0, 1'b0, p + 8);
    idle(2);
    chk("R2", "fetch_pc held in window", fetch_pc, p + 8);
    step("R4", 3'd0, 1'b0, 0, 0, 0, 1'b1, 2'd2, 1'b0, 1'b0, 32'h7000);
    idle(1);
  endtask

  initial begin
    t_reset();
    t_sequential();
    t_taken_eq();
    t_not_taken_ne();
    t_signed_zero();
    t_reserved_kind();
    t_likely_not_taken();
    t_likely_taken();
    t_branch_in_slot();
    t_stall();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule